// File: doc/BRIEF.md
# Audio Volume Ramp Sequencer

This block moves a channel's gain word from wherever it currently sits to a newly requested target, in a fixed number of equal increments. A start strobe captures the target, the step count and the sample-rate family. The block then applies one increment per step tick until the gain reaches the target. The step tick is derived from a free-running reference tick through a divider, and the family select picks the divider ratio. One step lasts four periods of the family base rate (44.1 kHz or 48 kHz). The ramp time therefore depends only on the family and the step count, never on which member rate is actually in use. With the default ratios and a 3.528 MHz reference tick, 512 steps take about 46.44 ms in the 44.1 kHz family and about 42.67 ms in the 48 kHz family. Each doubling of the step count doubles those figures.

The increment is the signed distance to the target divided by the step count, truncated toward zero. The last step writes the target itself, so any rounding remainder is absorbed there. A new start strobe during a ramp begins a fresh ramp from the gain present at that moment. A start whose target equals the present gain takes no steps and leaves the block idle. It also stops a ramp that is running.

Top module: `vol_ramp_seq`

## Requirements
- R1: After reset, gainOut equals the RESET_GAIN parameter and busy is low.
- R2: stepSel encodes the step count: 0 selects 512 steps, 1 selects 1024, and 2 or 3 select 2048.
- R3: rateFam 0 selects the 44.1 kHz family divider (DIV_FAM44 reference ticks per step) and rateFam 1 selects the 48 kHz family divider (DIV_FAM48). The k-th step is applied on the clock edge that samples the (k × divider)-th refTick pulse after the start edge, and the gain changes on no other edge.
- R4: Every step except the last adds the same signed increment, (target − start gain) / steps, truncated toward zero.
- R5: The final step sets gainOut exactly to the target, and busy falls on that same edge.
- R6: A start strobe with targetGain different from gainOut raises busy on the next edge.
- R7: A start strobe during a ramp restarts the ramp from the present gain toward the new target, with new pacing and a new increment.
- R8: A start strobe with targetGain equal to gainOut takes no steps. Busy is low after that edge, and a running ramp stops where it is.
- R9: Without a start strobe, changes on targetGain, stepSel and rateFam do not alter gainOut while idle.
- R10: Target, step count and family are captured at the start strobe. Changing those inputs during a ramp does not alter its increments or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference time-base pulse, one clock wide |
| rateFam | input | 1 | Sample-rate family: 0 = 44.1 kHz, 1 = 48 kHz |
| stepSel | input | 2 | Step-count select |
| targetGain | input | GAIN_W | Requested gain word |
| start | input | 1 | Begin a ramp toward targetGain |
| gainOut | output | GAIN_W | Present gain word |
| busy | output | 1 | High while a ramp is in progress |

## Verification
Busy is due on the first edge after the start edge. The k-th gain update is due on the edge at start edge + k × divider when refTick pulses every cycle. For each ramp, the driver computes every expected gain change together with the exact cycle it is due. The monitor samples on the falling edge and pops an item at each observed change, so a change that is early, late, missing or unexpected is reported with the cycle it happened in. Busy and the settled gain are checked at the falling edge after the start edge and after the edge that carries the last step.

// File: rtl/vol_ramp_pkg.sv
package vol_ramp_pkg;

  localparam int STEP_CNT_W = 12;

  typedef struct packed {
    logic load;     // capture target, increment and family
    logic advance;  // add one increment
    logic finish;   // write the target
    logic clear;    // stop without stepping
  } rampStrobes_t;

  function automatic logic [3:0] stepShift(input logic [1:0] sel);
    case (sel)
      2'd0:    stepShift = 4'd9;
      2'd1:    stepShift = 4'd10;
      default: stepShift = 4'd11;
    endcase
  endfunction

  function automatic logic [STEP_CNT_W-1:0] stepCount(input logic [1:0] sel);
    stepCount = STEP_CNT_W'(1) << stepShift(sel);
  endfunction

endpackage

// File: rtl/vol_ramp_pacer.sv
module vol_ramp_pacer
  import vol_ramp_pkg::*;
#(
  parameter int DIV_FAM44 = 320,
  parameter int DIV_FAM48 = 294
) (
  input  logic         clk,
  input  logic         rstN,
  input  rampStrobes_t strobes,
  input  logic         running,
  input  logic         refTick,
  input  logic         rateFam,
  output logic         stepTick
);
  localparam int DIV_MAX = (DIV_FAM44 > DIV_FAM48) ? DIV_FAM44 : DIV_FAM48;
  localparam int CNT_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] termCnt;
  logic             famQ;

  generate
    if (DIV_FAM44 == DIV_FAM48) begin : g_single_div
      assign termCnt = CNT_W'(DIV_FAM44 - 1);
    end else begin : g_dual_div
      assign termCnt = famQ ? CNT_W'(DIV_FAM48 - 1) : CNT_W'(DIV_FAM44 - 1);
    end
  endgenerate

  assign stepTick = running && refTick && (tickCnt == termCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      famQ    <= 1'b0;
    end else if (strobes.load) begin
      tickCnt <= '0;
      famQ    <= rateFam;
    end else if (running && refTick) begin
      tickCnt <= (tickCnt == termCnt) ? '0 : tickCnt + 1'b1;
    end
  end
endmodule

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl
  import vol_ramp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   stepSel,
  input  logic         atTarget,
  input  logic         stepTick,
  output rampStrobes_t strobes,
  output logic         busy
);
  logic                  busyQ;
  logic [STEP_CNT_W-1:0] stepsLeft;
  logic                  lastStep;

  assign lastStep = (stepsLeft == STEP_CNT_W'(1));
  assign busy     = busyQ;

  always_comb begin
    strobes = '0;
    if (start) begin
      strobes.clear = atTarget;
      strobes.load  = !atTarget;
    end else if (busyQ && stepTick) begin
      strobes.finish  = lastStep;
      strobes.advance = !lastStep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      stepsLeft <= '0;
    end else begin
      if (strobes.load) begin
        busyQ     <= 1'b1;
        stepsLeft <= stepCount(stepSel);
      end else if (strobes.clear || strobes.finish) begin
        busyQ     <= 1'b0;
        stepsLeft <= '0;
      end else if (strobes.advance) begin
        stepsLeft <= stepsLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vol_ramp_dp.sv
module vol_ramp_dp
  import vol_ramp_pkg::*;
#(
  parameter int          GAIN_W     = 24,
  parameter logic [GAIN_W-1:0] RESET_GAIN = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampStrobes_t      strobes,
  input  logic [GAIN_W-1:0] targetGain,
  input  logic [1:0]        stepSel,
  output logic              atTarget,
  output logic [GAIN_W-1:0] gainOut
);
  localparam int DW = GAIN_W + 1;

  logic [GAIN_W-1:0] gainQ;
  logic [GAIN_W-1:0] tgtQ;
  logic [DW-1:0]     incQ;
  logic [DW-1:0]     diff;
  logic [DW-1:0]     mag;
  logic [DW-1:0]     magShift;
  logic [DW-1:0]     incNext;
  logic [DW-1:0]     gainSum;

  assign diff     = {1'b0, targetGain} - {1'b0, gainQ};
  assign mag      = diff[DW-1] ? (~diff + 1'b1) : diff;
  assign magShift = mag >> stepShift(stepSel);
  assign incNext  = diff[DW-1] ? (~magShift + 1'b1) : magShift;
  assign gainSum  = {1'b0, gainQ} + incQ;
  assign atTarget = (targetGain == gainQ);
  assign gainOut  = gainQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainQ <= RESET_GAIN;
      tgtQ  <= RESET_GAIN;
      incQ  <= '0;
    end else begin
      if (strobes.load) begin
        tgtQ <= targetGain;
        incQ <= incNext;
      end
      if (strobes.finish) begin
        gainQ <= tgtQ;
      end else if (strobes.advance) begin
        gainQ <= gainSum[GAIN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vol_ramp_seq.sv
module vol_ramp_seq
  import vol_ramp_pkg::*;
#(
  parameter int          GAIN_W     = 24,
  parameter int          DIV_FAM44  = 320,
  parameter int          DIV_FAM48  = 294,
  parameter logic [GAIN_W-1:0] RESET_GAIN = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              rateFam,
  input  logic [1:0]        stepSel,
  input  logic [GAIN_W-1:0] targetGain,
  input  logic              start,
  output logic [GAIN_W-1:0] gainOut,
  output logic              busy
);
  rampStrobes_t strobes;
  logic         atTarget;
  logic         stepTick;

  vol_ramp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stepSel  (stepSel),
    .atTarget (atTarget),
    .stepTick (stepTick),
    .strobes  (strobes),
    .busy     (busy)
  );

  vol_ramp_pacer #(
    .DIV_FAM44 (DIV_FAM44),
    .DIV_FAM48 (DIV_FAM48)
  ) u_pacer (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .running  (busy),
    .refTick  (refTick),
    .rateFam  (rateFam),
    .stepTick (stepTick)
  );

  vol_ramp_dp #(
    .GAIN_W     (GAIN_W),
    .RESET_GAIN (RESET_GAIN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .targetGain (targetGain),
    .stepSel    (stepSel),
    .atTarget   (atTarget),
    .gainOut    (gainOut)
  );
endmodule

// File: rtl/vol_ramp_seq_chk.sv
module vol_ramp_seq_chk #(
  parameter int GAIN_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              refTick,
  input logic              start,
  input logic [GAIN_W-1:0] targetGain,
  input logic [GAIN_W-1:0] gainOut,
  input logic              busy
);
  logic [GAIN_W-1:0] tgtCap;

  always_ff @(posedge clk) begin
    if (!rstN) tgtCap <= gainOut;
    else if (start) tgtCap <= targetGain;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && targetGain != gainOut) |=> busy); // R6

  AST_EQUAL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (start && targetGain == gainOut) |=> (!busy && $stable(gainOut))); // R8

  AST_LANDS_ON_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (gainOut == tgtCap)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(gainOut)); // R9

  AST_TICK_PACED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !start) |=> ($stable(gainOut) || $past(refTick))); // R3
endmodule

bind vol_ramp_seq vol_ramp_seq_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refTick    (refTick),
  .start      (start),
  .targetGain (targetGain),
  .gainOut    (gainOut),
  .busy       (busy)
);

// File: tb/vol_ramp_seq_bench.sv
module vol_ramp_seq_bench;
  localparam int GW   = 16;
  localparam int D44  = 3;
  localparam int D48  = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refTick = 1'b1;
  logic          rateFam = 1'b0;
  logic [1:0]    stepSel = 2'd0;
  logic [GW-1:0] targetGain = '0;
  logic          start = 1'b0;
  logic [GW-1:0] gainOut;
  logic          busy;

  int  cyc = 0;
  int  nTests = 0;
  int  nFail = 0;
  bit  finished = 1'b0;
  bit  monOn = 1'b0;
  int  model = 0;
  int  expCyc[$];
  int  expGain[$];
  logic [GW-1:0] prevGain;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vol_ramp_seq #(
    .GAIN_W (GW), .DIV_FAM44 (D44), .DIV_FAM48 (D48), .RESET_GAIN ('0)
  ) u_vol_ramp_seq (
    .clk (clk), .rstN (rstN), .refTick (refTick), .rateFam (rateFam),
    .stepSel (stepSel), .targetGain (targetGain), .start (start),
    .gainOut (gainOut), .busy (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every gain change must match the next scheduled item
  always @(negedge clk) begin
    if (monOn && gainOut !== prevGain) begin
      if (expCyc.size() == 0) begin
        check(1'b0, "R9 unexpected gain change", int'(gainOut), int'(prevGain));
      end else begin
        int c, g;
        c = expCyc.pop_front();
        g = expGain.pop_front();
        check(cyc == c, "R3 step timing", cyc, c);
        check(int'(gainOut) == g, "R4 step value", int'(gainOut), g);
      end
    end
    prevGain = gainOut;
  end

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // launch a ramp; run the given number of steps (0 = all of them)
  task automatic ramp(input int tgt, input int sel, input int fam, input int upTo);
    int n, dv, inc, c0, last, prev;
    @(negedge clk);
    targetGain = GW'(tgt);
    stepSel    = 2'(sel);
    rateFam    = fam[0];
    start      = 1'b1;
    c0 = cyc + 1;
    n  = (sel == 0) ? 512 : (sel == 1) ? 1024 : 2048; // R2
    dv = fam ? D48 : D44;
    if (tgt == model) begin
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0, "R8 busy after equal start", busy, 0);
      check(int'(gainOut) == model, "R8 gain held", int'(gainOut), model);
      return;
    end
    inc  = (tgt - model) / n; // R4 truncation toward zero
    last = (upTo == 0) ? n : upTo;
    prev = model;
    for (int k = 1; k <= last; k++) begin
      int g;
      g = (k == n) ? tgt : model + k * inc; // R5
      if (g != prev) begin
        expCyc.push_back(c0 + dv * k);
        expGain.push_back(g);
      end
      prev = g;
    end
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    // R10: scramble the inputs during the ramp
    targetGain = ~GW'(tgt);
    stepSel    = 2'(sel ^ 1);
    rateFam    = ~fam[0];
    waitCyc(c0 + dv * last);
    model = prev;
    if (upTo == 0) begin
      check(busy == 1'b0, "R5 busy falls with last step", busy, 0);
      check(int'(gainOut) == tgt, "R5 lands on target", int'(gainOut), tgt);
    end else begin
      check(busy == 1'b1, "R7 busy before restart", busy, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(gainOut) == 0, "R1 reset gain", int'(gainOut), 0);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    rstN = 1'b1;
    prevGain = gainOut;
    monOn = 1'b1;
    @(negedge clk);

    ramp(16'h4000, 0, 0, 0);          // R2 512 steps, 44.1 family, exact increment
    ramp(16'h0123, 1, 1, 0);          // down, remainder absorbed, 48 family
    ramp(16'hFFFF, 2, 0, 100);        // R7 partial 2048-step ramp
    ramp(16'h1000, 3, 1, 0);          // R7 restart, 2048 via code 3
    ramp(16'h1005, 0, 0, 0);          // zero increment, single jump at the end
    ramp(16'h1005, 1, 1, 0);          // R8 equal target while idle
    ramp(16'h9000, 0, 1, 40);         // start, then stop it
    ramp(model, 0, 0, 0);             // R8 equal target aborts the ramp
    // R9: inputs move without start
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      targetGain = GW'(i * 997);
      stepSel    = 2'(i);
      rateFam    = i[0];
    end
    check(int'(gainOut) == model, "R9 gain held while idle", int'(gainOut), model);
    check(busy == 1'b0, "R9 busy low while idle", busy, 0);
    check(expCyc.size() == 0, "R3 all scheduled steps seen", expCyc.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule